// File: doc/BRIEF.md
# Widening Multiply-Accumulate Vector Unit

This unit executes a family of eight vector multiply-accumulate operations whose products are wider than their inputs. It receives a 32-bit instruction word together with three vector operands: an accumulator and two sources. The sources are packed with narrow elements. The unit splits the vector into wide lanes that are twice the narrow element width. For each wide lane it takes one narrow element from each source, either the even-positioned one or the odd-positioned one. It widens both elements, signed or unsigned, multiplies them, and then adds the product to the accumulator lane or subtracts it.

The instruction selects three things: the lane width, whether the operation adds or subtracts, and whether the operands are signed or unsigned. An encoding outside the group, or one with a lane size the group does not define, produces no result. In that case the unit raises its illegal flag and passes the accumulator through unchanged. The register number fields are not interpreted, because operand storage lives outside this unit. An operation presented with `inValid` produces its result exactly two clock cycles later, marked by `outValid`.

Top module: `wmac_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:24] are 01000100, bit 21 is 0, bits [15:13] are 010 and the size field [23:22] is not 00. Any other word gives `illegal`=1 with its result, and an accepted one gives `illegal`=0.
- R2: For a rejected instruction the reported `result` equals the accumulator vector given with it.
- R3: Size field 01, 10 and 11 select wide lanes of 16, 32 and 64 bits, built from narrow source elements of 8, 16 and 32 bits respectively. Wide lane i occupies result bits [i*W +: W].
- R4: Bit 10 = 0 makes wide lane i use narrow element 2*i of both sources. Bit 10 = 1 makes it use narrow element 2*i+1.
- R5: Bit 11 = 0 sign-extends both narrow elements to the lane width before multiplying. Bit 11 = 1 zero-extends them.
- R6: Bit 12 = 0 adds the widened product to the accumulator lane. Bit 12 = 1 subtracts it.
- R7: Each lane result wraps modulo 2^W, with no saturation and no carry between lanes.
- R8: `outValid` rises exactly two clock cycles after `inValid` is sampled high, and back-to-back operations are accepted every cycle. `result` and `illegal` change only in cycles with `outValid` high and hold otherwise.
- R9: With `rstN` low at a clock edge, `outValid`, `illegal` and `result` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operation presented this cycle |
| instr | input | 32 | Instruction word |
| accIn | input | VLEN | Accumulator vector |
| srcN | input | VLEN | First narrow-element source |
| srcM | input | VLEN | Second narrow-element source |
| outValid | output | 1 | Result available this cycle |
| result | output | VLEN | Updated destination vector |
| illegal | output | 1 | Encoding rejected for this result |

## Verification
The hardest case to reach is the one that separates odd from even element selection together with sign extension. A lane only reveals the wrong element or the wrong extension when the two candidate narrow elements differ and carry their sign bits set. The stimulus therefore uses source patterns whose adjacent narrow elements differ at every size, with many negative elements. It sweeps all eight operations at each of the three sizes against a lane-by-lane model. Back-to-back issue is exercised so that the decoded controls of one operation cannot leak into its neighbour's result.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  // Strobes and decoded fields passed from control to datapath
  typedef struct packed {
    logic       capture;   // load operand registers (stage 1)
    logic       commit;    // write result register (stage 2)
    logic       sub;       // subtract product
    logic       uns;       // zero-extend narrow elements
    logic       top;       // odd narrow elements
    logic [1:0] size;      // lane size code
    logic       illegal;   // encoding rejected
  } wmac_ctrl_t;

  localparam logic [7:0] GroupHigh = 8'b0100_0100;
  localparam logic [2:0] GroupMid  = 3'b010;
endpackage

// File: rtl/wmac_control.sv
module wmac_control
  import wmac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  output wmac_ctrl_t  ctrl,
  output logic        outValid,
  output logic        illegal
);
  logic       matchGroup;
  logic       decIllegal;
  logic       s1Valid;
  logic       s1Sub;
  logic       s1Uns;
  logic       s1Top;
  logic [1:0] s1Size;
  logic       s1Illegal;

  assign matchGroup = (instr[31:24] == GroupHigh) && !instr[21] && (instr[15:13] == GroupMid);
  assign decIllegal = !matchGroup || (instr[23:22] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Sub     <= 1'b0;
      s1Uns     <= 1'b0;
      s1Top     <= 1'b0;
      s1Size    <= 2'b00;
      s1Illegal <= 1'b0;
    end else begin
      s1Valid <= inValid;
      if (inValid) begin
        s1Sub     <= instr[12];
        s1Uns     <= instr[11];
        s1Top     <= instr[10];
        s1Size    <= instr[23:22];
        s1Illegal <= decIllegal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) illegal <= s1Illegal;
    end
  end

  always_comb begin
    ctrl.capture = inValid;
    ctrl.commit  = s1Valid;
    ctrl.sub     = s1Sub;
    ctrl.uns     = s1Uns;
    ctrl.top     = s1Top;
    ctrl.size    = s1Size;
    ctrl.illegal = s1Illegal;
  end
endmodule

// File: rtl/wmac_datapath.sv
module wmac_datapath
  import wmac_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  wmac_ctrl_t      ctrl,
  input  logic [VLEN-1:0] accIn,
  input  logic [VLEN-1:0] srcN,
  input  logic [VLEN-1:0] srcM,
  output logic [VLEN-1:0] result
);
  localparam int NumSizes = 3;

  logic [VLEN-1:0] accQ;
  logic [VLEN-1:0] nQ;
  logic [VLEN-1:0] mQ;
  logic [NumSizes-1:0][VLEN-1:0] sizeRes;
  logic [VLEN-1:0] laneMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      nQ   <= '0;
      mQ   <= '0;
    end else if (ctrl.capture) begin
      accQ <= accIn;
      nQ   <= srcN;
      mQ   <= srcM;
    end
  end

  for (genvar s = 0; s < NumSizes; s++) begin : g_size
    localparam int DW    = 16 << s;
    localparam int NW    = DW / 2;
    localparam int LANES = VLEN / DW;
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [NW-1:0] elemA;
      logic [NW-1:0] elemB;
      logic [DW-1:0] wideA;
      logic [DW-1:0] wideB;
      logic [DW-1:0] prod;
      logic [DW-1:0] accLane;

      assign elemA   = ctrl.top ? nQ[(2*i+1)*NW +: NW] : nQ[(2*i)*NW +: NW];
      assign elemB   = ctrl.top ? mQ[(2*i+1)*NW +: NW] : mQ[(2*i)*NW +: NW];
      assign wideA   = ctrl.uns ? {{NW{1'b0}}, elemA} : {{NW{elemA[NW-1]}}, elemA};
      assign wideB   = ctrl.uns ? {{NW{1'b0}}, elemB} : {{NW{elemB[NW-1]}}, elemB};
      assign prod    = wideA * wideB;
      assign accLane = accQ[i*DW +: DW];
      assign sizeRes[s][i*DW +: DW] = ctrl.sub ? (accLane - prod) : (accLane + prod);
    end
  end

  always_comb begin
    unique case (ctrl.size)
      2'b01:   laneMux = sizeRes[0];
      2'b10:   laneMux = sizeRes[1];
      2'b11:   laneMux = sizeRes[2];
      default: laneMux = accQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (ctrl.commit) begin
      result <= ctrl.illegal ? accQ : laneMux;
    end
  end
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
  import wmac_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] accIn,
  input  logic [VLEN-1:0] srcN,
  input  logic [VLEN-1:0] srcM,
  output logic            outValid,
  output logic [VLEN-1:0] result,
  output logic            illegal
);
  wmac_ctrl_t ctrl;

  wmac_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .instr    (instr),
    .ctrl     (ctrl),
    .outValid (outValid),
    .illegal  (illegal)
  );

  wmac_datapath #(.VLEN(VLEN)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .accIn  (accIn),
    .srcN   (srcN),
    .srcM   (srcM),
    .result (result)
  );
endmodule

// File: rtl/wmac_checker.sv
module wmac_checker #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [31:0]     instr,
  input logic [VLEN-1:0] accIn,
  input logic            outValid,
  input logic [VLEN-1:0] result,
  input logic            illegal
);
  logic            vd1, vd2;
  logic [31:0]     id1, id2;
  logic [VLEN-1:0] ad1, ad2;
  logic            expBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vd1 <= 1'b0; vd2 <= 1'b0;
      id1 <= '0;   id2 <= '0;
      ad1 <= '0;   ad2 <= '0;
    end else begin
      vd1 <= inValid; vd2 <= vd1;
      id1 <= instr;   id2 <= id1;
      ad1 <= accIn;   ad2 <= ad1;
    end
  end

  assign expBad = (id2[31:24] != 8'h44) || id2[21] || (id2[15:13] != 3'b010) || (id2[23:22] == 2'b00);

  // R8: fixed two-cycle latency
  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN) outValid == vd2);
  // R1: flag matches the encoding of the operation two cycles back
  p_illegal_flag_r1: assert property (@(posedge clk) disable iff (!rstN) outValid |-> (illegal == expBad));
  // R2: rejected operation passes the accumulator through
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN) (outValid && illegal) |-> (result == ad2));
  // R8: outputs hold between results
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> ($stable(result) && $stable(illegal)));
endmodule

bind wmac_unit wmac_checker #(.VLEN(VLEN)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .instr    (instr),
  .accIn    (accIn),
  .outValid (outValid),
  .result   (result),
  .illegal  (illegal)
);

// File: tb/wmac_unit_test.sv
module wmac_unit_test;
  localparam int VL = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VL-1:0] accIn = '0;
  logic [VL-1:0] srcN = '0;
  logic [VL-1:0] srcM = '0;
  logic          outValid;
  logic [VL-1:0] result;
  logic          illegal;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wmac_unit #(.VLEN(VL)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .accIn(accIn), .srcN(srcN), .srcM(srcM),
    .outValid(outValid), .result(result), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input logic sub, input logic uns, input logic top, input logic [1:0] sz);
    return {8'b0100_0100, sz, 1'b0, 5'd3, 3'b010, sub, uns, top, 5'd7, 5'd9};
  endfunction

  function automatic logic isBad(input logic [31:0] ins);
    return (ins[31:24] != 8'h44) || ins[21] || (ins[15:13] != 3'b010) || (ins[23:22] == 2'b00);
  endfunction

  function automatic logic [VL-1:0] model(input logic [31:0] ins, input logic [VL-1:0] acc,
                                          input logic [VL-1:0] n, input logic [VL-1:0] m);
    logic [VL-1:0] res;
    logic [63:0] a, b, al, r, mask;
    int dw, nw, idx;
    if (isBad(ins)) return acc;
    res = '0;
    dw = 8 << ins[23:22];
    nw = dw / 2;
    mask = (64'h1 << nw) - 64'h1;
    for (int i = 0; i < VL / dw; i++) begin
      idx = 2 * i + int'(ins[10]);
      a = 64'(n >> (idx * nw)) & mask;
      b = 64'(m >> (idx * nw)) & mask;
      if (!ins[11] && a[nw-1]) a = a | ~mask;
      if (!ins[11] && b[nw-1]) b = b | ~mask;
      al = 64'(acc >> (i * dw));
      r = ins[12] ? (al - a * b) : (al + a * b);
      for (int k = 0; k < dw; k++) res[i*dw+k] = r[k];
    end
    return res;
  endfunction

  task automatic chk(input string tag, input logic [VL-1:0] got, input logic [VL-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Issue one operation and check its result and the hold cycle after it
  task automatic issue(input string tag, input logic [31:0] ins, input logic [VL-1:0] acc,
                       input logic [VL-1:0] n, input logic [VL-1:0] m);
    logic [VL-1:0] exp;
    exp = model(ins, acc, n, m);
    @(negedge clk);
    inValid = 1'b1; instr = ins; accIn = acc; srcN = n; srcM = m;
    @(negedge clk);
    inValid = 1'b0; instr = '0; accIn = '1; srcN = '1; srcM = '1;
    chk({tag, " R8 not yet valid"}, VL'(outValid), VL'(0));
    @(negedge clk);
    chk({tag, " R8 valid"}, VL'(outValid), VL'(1));
    chk(tag, result, exp);
    chk({tag, " R1 flag"}, VL'(illegal), VL'(isBad(ins)));
    @(negedge clk);
    chk({tag, " R8 hold"}, {result[VL-2:0], outValid}, {exp[VL-2:0], 1'b0});
  endtask

  localparam logic [VL-1:0] PatA = 128'h80FF_7F01_C33C_A55A_0123_4567_89AB_CDEF;
  localparam logic [VL-1:0] PatB = 128'hFE80_017F_8000_7FFF_F00D_BEEF_DEAD_8181;
  localparam logic [VL-1:0] PatC = 128'h1111_2222_3333_4444_9999_AAAA_BBBB_CCCC;

  task automatic testReset();
    chk("R9 outValid", VL'(outValid), VL'(0));
    chk("R9 illegal", VL'(illegal), VL'(0));
    chk("R9 result", result, '0);
  endtask

  task automatic testSweep();
    for (int sz = 1; sz < 4; sz++) begin
      for (int op = 0; op < 8; op++) begin
        issue("R3 R4 R5 R6 sweep1", mk(op[2], op[1], op[0], 2'(sz)), PatC, PatA, PatB);
        issue("R3 R4 R5 R6 sweep2", mk(op[2], op[1], op[0], 2'(sz)), PatA, PatB, PatA);
      end
    end
  endtask

  task automatic testWrap();
    issue("R7 unsigned add wrap", mk(1'b0, 1'b1, 1'b0, 2'b01), '1, '1, '1);
    issue("R7 signed sub wrap", mk(1'b1, 1'b0, 1'b1, 2'b11), '0, {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}});
    issue("R7 unsigned sub wrap", mk(1'b1, 1'b1, 1'b0, 2'b10), '0, '1, '1);
  endtask

  task automatic testIllegal();
    issue("R1 R2 size zero", mk(1'b0, 1'b0, 1'b0, 2'b00), PatA, PatB, PatC);
    issue("R1 R2 bit21 set", mk(1'b0, 1'b0, 1'b0, 2'b01) | 32'h0020_0000, PatB, PatA, PatC);
    issue("R1 R2 wrong mid bits", mk(1'b1, 1'b0, 1'b0, 2'b10) ^ 32'h0000_2000, PatC, PatA, PatB);
    issue("R1 R2 wrong high byte", mk(1'b0, 1'b1, 1'b1, 2'b11) ^ 32'h0100_0000, PatA, PatC, PatB);
    issue("R1 legal after illegal", mk(1'b0, 1'b0, 1'b0, 2'b01), PatA, PatB, PatC);
  endtask

  task automatic testBackToBack();
    logic [31:0] i1, i2;
    logic [VL-1:0] e1, e2;
    i1 = mk(1'b1, 1'b0, 1'b1, 2'b01);
    i2 = mk(1'b0, 1'b1, 1'b0, 2'b11);
    e1 = model(i1, PatA, PatB, PatC);
    e2 = model(i2, PatC, PatA, PatB);
    @(negedge clk);
    inValid = 1'b1; instr = i1; accIn = PatA; srcN = PatB; srcM = PatC;
    @(negedge clk);
    instr = i2; accIn = PatC; srcN = PatA; srcM = PatB;
    @(negedge clk);
    inValid = 1'b0; instr = '0;
    chk("R8 b2b first valid", VL'(outValid), VL'(1));
    chk("R8 b2b first result", result, e1);
    @(negedge clk);
    chk("R8 b2b second valid", VL'(outValid), VL'(1));
    chk("R8 b2b second result", result, e2);
    @(negedge clk);
    chk("R8 b2b idle", VL'(outValid), VL'(0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSweep();
    testWrap();
    testIllegal();
    testBackToBack();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule